// File: doc/BRIEF.md
# Programmable Peripheral Interface Unit

This block connects a processor bus to two peripheral ports, A and B. The processor reaches it over one shared bidirectional data bus, qualified by an active-low chip select, separate active-low read and write strobes, and a two-bit register select taken from the two lowest address bits. Four registers can be addressed: the port A data register, the port B data register, a control register and a status register.

Toward the devices, each port has its own input buffer and its own output buffer. Both are valid/ready streams. On the input stream, the port raises ready only while it is set to input and its input buffer is empty. A device beat is taken on a cycle where valid and ready are both high, and the data waits in the buffer until the processor reads it. Back-pressure is held until that read. On the output stream, a processor write presents the data with valid high. Valid and data then hold steady until the device returns ready. A second write during that wait is refused and recorded as an error.

The bus is synchronous to the clock. Each clock cycle in which the unit is selected and exactly one strobe is low is one access. Read data appears on the bus during the cycle itself. Register updates caused by the access take effect at the end of that cycle.

Top module: `pio_unit`

## Requirements
- R1: While bus_cs_n is high, the unit leaves the data bus undriven, and no strobe or data value changes any register.
- R2: A read is bus_rd_n=0 with bus_wr_n=1. During that cycle the unit drives the selected register onto the bus. The select encoding is 0 = port A input buffer, 1 = port B input buffer, 2 = control, 3 = status. A control read returns the direction bits in bits 1:0 and zeros above them.
- R3: A write is bus_rd_n=1 with bus_wr_n=0, and it loads the selected register from the bus. In the control register, bit 0 sets the direction of port A and bit 1 sets the direction of port B, where 1 means output and 0 means input.
- R4: A cycle with both strobes low is ignored. Nothing is driven onto the bus and no register changes.
- R5: The status register has this layout. Bit 0 is port A input full. Bit 1 is port A output empty. Bit 2 is port B input full. Bit 3 is port B output empty. Bit 4 is overrun. Bit 5 is underrun. The bits above read zero. After reset the status register reads 0x0A and the control register reads 0x00.
- R6: A port's in_ready equals (input buffer not full) AND (direction is input). A valid/ready beat loads the buffer and sets its full flag. A processor read of that port clears the flag.
- R7: A write to a port set to output loads the output buffer and raises out_valid with that data, provided the buffer is empty. out_valid falls after a cycle in which out_ready is high. A write to a port set to input has no effect.
- R8: A write to an output port whose out_valid is still high sets the overrun bit. The pending data is kept unchanged.
- R9: A read of a port input buffer that is not full sets the underrun bit.
- R10: The overrun and underrun bits stay set until a control write carries a 1 in bit 4 or bit 5 respectively. Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs_n | input | 1 | Active-low unit select |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_sel | input | 2 | Register select from address bits 1:0 |
| bus_data | inout | DW | Shared processor data bus |
| pa_in_data | input | DW | Port A device input data |
| pa_in_valid | input | 1 | Port A device input valid |
| pa_in_ready | output | 1 | Port A can accept input |
| pa_out_data | output | DW | Port A data toward device |
| pa_out_valid | output | 1 | Port A output data pending |
| pa_out_ready | input | 1 | Port A device takes output |
| pb_in_data | input | DW | Port B device input data |
| pb_in_valid | input | 1 | Port B device input valid |
| pb_in_ready | output | 1 | Port B can accept input |
| pb_out_data | output | DW | Port B data toward device |
| pb_out_valid | output | 1 | Port B output data pending |
| pb_out_ready | input | 1 | Port B device takes output |

## Verification
Several properties are checked on every cycle. The decoder never flags more than one access. An accepted device beat always leaves the input buffer full. An output handshake always empties the output buffer. Data pending during an overrun stays stable. The error bits are sticky. The direction bits stay still while the unit is deselected. Other behaviour shows up only in the bench scenarios, which compare against an independent model of the whole register map. These scenarios cover the value read back on the bus for each select code, the exact status encoding, refused writes to an input-direction port or to the status register, and accesses that are deselected or have both strobes low.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int NPORT = 2;

  typedef enum logic [1:0] {
    SEL_PA   = 2'd0,
    SEL_PB   = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_STAT = 2'd3
  } sel_e;

  // status bit positions
  localparam int ST_A_FULL  = 0;
  localparam int ST_A_EMPTY = 1;
  localparam int ST_B_FULL  = 2;
  localparam int ST_B_EMPTY = 3;
  localparam int ST_OVR     = 4;
  localparam int ST_UDR     = 5;
endpackage

// File: rtl/pio_decode.sv
module pio_decode (
  input  logic       bus_cs_n,
  input  logic       bus_rd_n,
  input  logic       bus_wr_n,
  input  logic [1:0] bus_sel,
  output logic [3:0] rd_hit,
  output logic [3:0] wr_hit,
  output logic       drive_en
);
  logic access, rd_acc, wr_acc;

  // exactly one strobe low under select forms an access
  assign access   = !bus_cs_n && (bus_rd_n ^ bus_wr_n);
  assign rd_acc   = access && !bus_rd_n;
  assign wr_acc   = access && !bus_wr_n;
  assign rd_hit   = rd_acc ? (4'b0001 << bus_sel) : 4'b0000;
  assign wr_hit   = wr_acc ? (4'b0001 << bus_sel) : 4'b0000;
  assign drive_en = rd_acc;

  // R2
  always_comb begin
    strobe_onehot_chk: assert ($onehot0({rd_hit, wr_hit}));
  end
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_out,
  input  logic          wr_hit,
  input  logic          rd_hit,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic [DW-1:0] in_buf,
  output logic          in_full,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          ovr_evt,
  output logic          udr_evt
);
  logic push, wr_ok, wr_accept;

  assign in_ready  = !in_full && !dir_out;
  assign push      = in_valid && in_ready;
  assign wr_ok     = wr_hit && dir_out;
  assign wr_accept = wr_ok && !out_valid;
  assign ovr_evt   = wr_ok && out_valid;
  assign udr_evt   = rd_hit && !in_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_full   <= 1'b0;
      in_buf    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (push) begin
        in_full <= 1'b1;
        in_buf  <= in_data;
      end else if (rd_hit) begin
        in_full <= 1'b0;
      end
      if (wr_accept) begin
        out_valid <= 1'b1;
        out_data  <= wdata;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R6
  push_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> in_full);
  // R7
  out_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);
  // R8
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && dir_out && out_valid) |=> $stable(out_data));
endmodule

// File: rtl/pio_unit.sv
module pio_unit #(
  parameter int DW = 8  // at least 6, so the status bits fit
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs_n,
  input  logic          bus_rd_n,
  input  logic          bus_wr_n,
  input  logic [1:0]    bus_sel,
  inout  wire  [DW-1:0] bus_data,
  input  logic [DW-1:0] pa_in_data,
  input  logic          pa_in_valid,
  output logic          pa_in_ready,
  output logic [DW-1:0] pa_out_data,
  output logic          pa_out_valid,
  input  logic          pa_out_ready,
  input  logic [DW-1:0] pb_in_data,
  input  logic          pb_in_valid,
  output logic          pb_in_ready,
  output logic [DW-1:0] pb_out_data,
  output logic          pb_out_valid,
  input  logic          pb_out_ready
);
  import pio_pkg::*;

  logic [3:0] rd_hit, wr_hit;
  logic       drive_en;
  logic [NPORT-1:0] dir_q;
  logic       ovr_q, udr_q, ctl_wr;
  logic [DW-1:0] rdata, status;

  logic [NPORT-1:0][DW-1:0] p_in_d, p_in_buf, p_out_d;
  logic [NPORT-1:0] p_in_v, p_in_r, p_full, p_out_v, p_out_r, p_ovr, p_udr;

  pio_decode u_dec (
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_sel(bus_sel), .rd_hit(rd_hit), .wr_hit(wr_hit), .drive_en(drive_en)
  );

  assign p_in_d[0]  = pa_in_data;
  assign p_in_v[0]  = pa_in_valid;
  assign p_out_r[0] = pa_out_ready;
  assign p_in_d[1]  = pb_in_data;
  assign p_in_v[1]  = pb_in_valid;
  assign p_out_r[1] = pb_out_ready;

  assign pa_in_ready  = p_in_r[0];
  assign pa_out_data  = p_out_d[0];
  assign pa_out_valid = p_out_v[0];
  assign pb_in_ready  = p_in_r[1];
  assign pb_out_data  = p_out_d[1];
  assign pb_out_valid = p_out_v[1];

  // select codes 0 and 1 map onto port index
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pio_port #(.DW(DW)) u_port (
      .clk(clk), .rst_n(rst_n), .dir_out(dir_q[p]),
      .wr_hit(wr_hit[p]), .rd_hit(rd_hit[p]), .wdata(bus_data),
      .in_data(p_in_d[p]), .in_valid(p_in_v[p]), .in_ready(p_in_r[p]),
      .in_buf(p_in_buf[p]), .in_full(p_full[p]),
      .out_data(p_out_d[p]), .out_valid(p_out_v[p]), .out_ready(p_out_r[p]),
      .ovr_evt(p_ovr[p]), .udr_evt(p_udr[p])
    );
  end

  assign ctl_wr = wr_hit[SEL_CTL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      ovr_q <= 1'b0;
      udr_q <= 1'b0;
    end else begin
      if (ctl_wr) dir_q <= bus_data[NPORT-1:0];
      ovr_q <= (|p_ovr) || (ovr_q && !(ctl_wr && bus_data[ST_OVR]));
      udr_q <= (|p_udr) || (udr_q && !(ctl_wr && bus_data[ST_UDR]));
    end
  end

  always_comb begin
    status             = '0;
    status[ST_A_FULL]  = p_full[0];
    status[ST_A_EMPTY] = !p_out_v[0];
    status[ST_B_FULL]  = p_full[1];
    status[ST_B_EMPTY] = !p_out_v[1];
    status[ST_OVR]     = ovr_q;
    status[ST_UDR]     = udr_q;
  end

  always_comb begin
    case (sel_e'(bus_sel))
      SEL_PA:  rdata = p_in_buf[0];
      SEL_PB:  rdata = p_in_buf[1];
      SEL_CTL: rdata = {{(DW-NPORT){1'b0}}, dir_q};
      default: rdata = status;
    endcase
  end

  assign bus_data = drive_en ? rdata : {DW{1'bz}};

  // R10
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !(ctl_wr && bus_data[ST_OVR])) |=> ovr_q);
  // R1
  desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs_n |=> $stable(dir_q));
endmodule

// File: tb/test_pio_unit.sv
module test_pio_unit;
  localparam int DW = 8;
  logic clk = 0, rst_n = 0;
  logic bus_cs_n = 1, bus_rd_n = 1, bus_wr_n = 1;
  logic [1:0] bus_sel = 0;
  wire  [DW-1:0] bus_data;
  logic tb_oe = 0;
  logic [DW-1:0] tb_val = 0;
  logic [DW-1:0] pa_in_data = 0, pb_in_data = 0;
  logic pa_in_valid = 0, pb_in_valid = 0, pa_out_ready = 0, pb_out_ready = 0;
  logic pa_in_ready, pb_in_ready, pa_out_valid, pb_out_valid;
  logic [DW-1:0] pa_out_data, pb_out_data;
  int checks = 0, errs = 0;

  assign bus_data = tb_oe ? tb_val : {DW{1'bz}};
  always #10 clk = ~clk;

  pio_unit #(.DW(DW)) i_pio_unit (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_sel(bus_sel), .bus_data(bus_data),
    .pa_in_data(pa_in_data), .pa_in_valid(pa_in_valid), .pa_in_ready(pa_in_ready),
    .pa_out_data(pa_out_data), .pa_out_valid(pa_out_valid), .pa_out_ready(pa_out_ready),
    .pb_in_data(pb_in_data), .pb_in_valid(pb_in_valid), .pb_in_ready(pb_in_ready),
    .pb_out_data(pb_out_data), .pb_out_valid(pb_out_valid), .pb_out_ready(pb_out_ready)
  );

  // behavioural reference model
  logic [1:0] m_dir;
  logic m_full[2], m_ov[2], m_ovr, m_udr;
  logic [7:0] m_in[2], m_od[2];
  logic t_acc, t_rd, t_wr, t_sov, t_sud, t_pend, t_iv, t_ordy;
  logic [7:0] t_d, t_idat;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = 0; m_ovr = 0; m_udr = 0;
      for (int p = 0; p < 2; p++) begin
        m_full[p] = 0; m_ov[p] = 0; m_in[p] = 0; m_od[p] = 0;
      end
    end else begin
      t_acc = !bus_cs_n && (bus_rd_n != bus_wr_n);
      t_rd = t_acc && !bus_rd_n;
      t_wr = t_acc && !bus_wr_n;
      t_d = bus_data;
      t_sov = 0; t_sud = 0;
      for (int p = 0; p < 2; p++) begin
        t_iv = (p == 0) ? pa_in_valid : pb_in_valid;
        t_idat = (p == 0) ? pa_in_data : pb_in_data;
        t_ordy = (p == 0) ? pa_out_ready : pb_out_ready;
        if (t_iv && !m_full[p] && !m_dir[p]) begin
          m_full[p] = 1; m_in[p] = t_idat;
        end else if (t_rd && bus_sel == p) begin
          if (!m_full[p]) t_sud = 1;
          m_full[p] = 0;
        end
        t_pend = m_ov[p];
        if (t_pend && t_ordy) m_ov[p] = 0;
        if (t_wr && bus_sel == p && m_dir[p]) begin
          if (t_pend) t_sov = 1;
          else begin m_ov[p] = 1; m_od[p] = t_d; end
        end
      end
      if (t_wr && bus_sel == 2) begin
        m_dir = t_d[1:0];
        if (t_d[4]) m_ovr = 0;
        if (t_d[5]) m_udr = 0;
      end
      if (t_sov) m_ovr = 1;
      if (t_sud) m_udr = 1;
    end
  end

  function automatic logic [7:0] model_read(input logic [1:0] s);
    case (s)
      2'd0: return m_in[0];
      2'd1: return m_in[1];
      2'd2: return {6'b0, m_dir};
      default: return {2'b0, m_udr, m_ovr, !m_ov[1], m_full[1], !m_ov[0], m_full[0]};
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of device-side outputs
  always @(negedge clk) begin
    if (rst_n) begin
      chk(pa_out_valid == m_ov[0], "R7 A valid", {7'b0, pa_out_valid}, {7'b0, m_ov[0]});
      chk(pb_out_valid == m_ov[1], "R7 B valid", {7'b0, pb_out_valid}, {7'b0, m_ov[1]});
      if (m_ov[0]) chk(pa_out_data == m_od[0], "R8 A data", pa_out_data, m_od[0]);
      if (m_ov[1]) chk(pb_out_data == m_od[1], "R8 B data", pb_out_data, m_od[1]);
      chk(pa_in_ready == (!m_full[0] && !m_dir[0]), "R6 A ready", {7'b0, pa_in_ready}, 8'h0);
      chk(pb_in_ready == (!m_full[1] && !m_dir[1]), "R6 B ready", {7'b0, pb_in_ready}, 8'h0);
    end
  end

  task automatic bus_read(input logic [1:0] s, input logic [7:0] exp, input string tag);
    logic [7:0] got;
    @(negedge clk);
    bus_cs_n = 0; bus_rd_n = 0; bus_sel = s;
    #5 got = bus_data;
    chk(got == exp, tag, got, exp);
    chk(got == model_read(s), {tag, " model"}, got, model_read(s));
    @(negedge clk);
    bus_cs_n = 1; bus_rd_n = 1;
  endtask

  task automatic bus_cycle(input logic cs, input logic rd, input logic wr,
                           input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    bus_cs_n = cs; bus_rd_n = rd; bus_wr_n = wr; bus_sel = s;
    tb_oe = 1; tb_val = d;
    @(negedge clk);
    bus_cs_n = 1; bus_rd_n = 1; bus_wr_n = 1; tb_oe = 0;
  endtask

  task automatic bus_write(input logic [1:0] s, input logic [7:0] d);
    bus_cycle(0, 1, 0, s, d);
  endtask

  task automatic dev_push(input int p, input logic [7:0] d);
    @(negedge clk);
    if (p == 0) begin pa_in_valid = 1; pa_in_data = d; end
    else begin pb_in_valid = 1; pb_in_data = d; end
    @(negedge clk);
    pa_in_valid = 0; pb_in_valid = 0;
  endtask

  task automatic dev_take(input int p);
    @(negedge clk);
    if (p == 0) pa_out_ready = 1; else pb_out_ready = 1;
    @(negedge clk);
    pa_out_ready = 0; pb_out_ready = 0;
  endtask

  initial begin
    #(20 * 200000);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    bus_read(2'd3, 8'h0A, "R5 reset status");
    bus_read(2'd2, 8'h00, "R2 reset control");
    bus_cycle(1, 1, 0, 2'd2, 8'h03);          // deselected write
    bus_read(2'd2, 8'h00, "R1 deselected write");
    bus_cycle(0, 0, 0, 2'd2, 8'h03);          // both strobes low
    bus_read(2'd2, 8'h00, "R4 both strobes");
    bus_write(2'd2, 8'h01);
    bus_read(2'd2, 8'h01, "R3 control write");
    bus_write(2'd0, 8'h5A);
    chk(pa_out_valid && pa_out_data == 8'h5A, "R7 A write", pa_out_data, 8'h5A);
    bus_read(2'd3, 8'h08, "R5 A pending");
    bus_write(2'd0, 8'h77);
    chk(pa_out_data == 8'h5A, "R8 data kept", pa_out_data, 8'h5A);
    bus_read(2'd3, 8'h18, "R8 overrun flag");
    dev_take(0);
    bus_read(2'd3, 8'h1A, "R10 still sticky");
    bus_write(2'd2, 8'h11);
    bus_read(2'd3, 8'h0A, "R10 overrun cleared");
    bus_write(2'd1, 8'h33);
    chk(!pb_out_valid, "R7 input-dir write", {7'b0, pb_out_valid}, 8'h0);
    bus_read(2'd3, 8'h0A, "R7 status untouched");
    dev_push(1, 8'hC3);
    chk(!pb_in_ready, "R6 B full", {7'b0, pb_in_ready}, 8'h0);
    bus_read(2'd3, 8'h0E, "R6 B full flag");
    bus_read(2'd1, 8'hC3, "R2 read port B");
    bus_read(2'd3, 8'h0A, "R6 full cleared");
    bus_read(2'd1, 8'hC3, "R9 empty read");
    bus_read(2'd3, 8'h2A, "R9 underrun flag");
    bus_write(2'd3, 8'h00);
    bus_read(2'd3, 8'h2A, "R10 status write ignored");
    dev_push(0, 8'h44);                        // A is output: refused
    bus_read(2'd3, 8'h2A, "R6 A refused");
    bus_write(2'd2, 8'h22);
    bus_read(2'd3, 8'h0A, "R10 underrun cleared");
    bus_read(2'd2, 8'h02, "R3 directions swapped");
    dev_push(0, 8'h96);
    bus_read(2'd0, 8'h96, "R2 read port A");
    bus_write(2'd1, 8'hE1);
    chk(pb_out_valid && pb_out_data == 8'hE1, "R7 B write", pb_out_data, 8'hE1);
    bus_read(2'd3, 8'h02, "R5 B pending");
    dev_take(1);
    bus_read(2'd3, 8'h0A, "R7 B drained");
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule